// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by combining two predictors that look at the branch from different angles. The first is the per-branch (local) predictor. It uses the fetch PC to pick a private history register, and that register's recent outcomes select a 2-bit saturating counter. The second is the global predictor. It uses one shared shift register that holds the outcomes of the most recent branches, and that register indexes a second table of 2-bit counters. A third table holds one 2-bit selector counter per branch slot. Each selector learns which of the two predictors has been more reliable for the branches that map to its slot.

The front end presents a PC on the fetch port. One cycle later the block returns the final direction together with both component directions. The pipeline keeps the component directions alongside the branch. When the branch resolves, the pipeline returns the PC, the real outcome and those saved component directions on the resolve port. The block then trains both counter tables, shifts both histories and adjusts the selector.

Top module: `tourn_predictor`

## Requirements
- R1: A synchronous active-high reset sets every local and global counter to weakly not-taken (01) and every selector to weakly-local (01). It clears all history registers to zero and holds `pred_valid` low.
- R2: A fetch sampled at a clock edge produces `pred_valid` high for exactly the following cycle, with all three prediction outputs registered at that same edge.
- R3: The local history register is chosen by PC bits [11:2] (default sizing). Its 10-bit value selects one of 1024 local counters, and `pred_local` is bit 1 of that counter.
- R4: The 12-bit global history register selects one of 4096 global counters, and `pred_global` is bit 1 of that counter.
- R5: `pred_taken` equals `pred_global` when bit 1 of the selector at PC bits [11:2] is 1, and equals `pred_local` otherwise.
- R6: On each resolve, the outcome (1 = taken) shifts into bit 0 of the addressed local history register and into bit 0 of the global history register. The older bits move one place up and the top bit is dropped.
- R7: On each resolve, the local counter selected by the pre-shift local history and the global counter selected by the pre-shift global history both step by +1 for taken and by -1 for not-taken. The step does not depend on the saved predictions, and counts stay within 0..3.
- R8: The selector at the resolved PC steps by +1 (capped at 3) when only the saved global prediction matched the outcome. It steps by -1 (floored at 0) when only the saved local prediction matched. It is unchanged when both matched or both missed.
- R9: A fetch and a resolve in the same cycle give a prediction taken from the tables as they stood before that resolve.
- R10: PCs that differ only above bit 11 or in bits [1:0] share all per-branch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | A branch PC is presented for prediction |
| fetch_pc | input | 32 | PC of the branch being fetched |
| pred_valid | output | 1 | Prediction outputs are valid this cycle |
| pred_taken | output | 1 | Final predicted direction (1 = taken) |
| pred_local | output | 1 | Local component direction, saved for training |
| pred_global | output | 1 | Global component direction, saved for training |
| res_valid | input | 1 | A resolved conditional branch is presented |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Actual outcome (1 = taken) |
| res_local | input | 1 | Local direction that was saved at fetch |
| res_global | input | 1 | Global direction that was saved at fetch |

## Verification
A wrong history bit or counter step does not appear at the ports straight away. It shows only when a later fetch indexes the damaged entry, so the bench compares every prediction against a reference model and fetches between resolves. A wrong global history pattern misdirects the very next fetch of any PC. A selector fault only shows as `pred_taken` following the wrong component, so saved predictions are also driven at random, independent of the real component outputs, to move selectors in both directions. Aliased PCs and same-cycle fetch/resolve pairs are checked directly.

// File: rtl/tourn_pkg.sv
package tourn_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LOW = 2'b01;

  // Saturating 2-bit step: up when inc is set, down otherwise
  function automatic ctr2_t ctr_step(ctr2_t c, logic inc);
    ctr2_t n;
    if (inc) n = (c == 2'd3) ? c : c + 2'd1;
    else     n = (c == 2'd0) ? c : c - 2'd1;
    return n;
  endfunction
endpackage

// File: rtl/tourn_local.sv
module tourn_local
  import tourn_pkg::*;
#(
  parameter int ENTRIES = 1024,
  parameter int HIST_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(ENTRIES)-1:0] f_idx,
  output logic                       f_dir,
  input  logic                       r_valid,
  input  logic [$clog2(ENTRIES)-1:0] r_idx,
  input  logic                       r_taken
);
  localparam int CTR_N = 1 << HIST_W;

  logic [HIST_W-1:0] hist_tbl [ENTRIES];
  ctr2_t             ctr_tbl  [CTR_N];
  logic [HIST_W-1:0] r_hist;

  assign f_dir  = ctr_tbl[hist_tbl[f_idx]][1];
  assign r_hist = hist_tbl[r_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) hist_tbl[i] <= '0;
      for (int j = 0; j < CTR_N; j++)   ctr_tbl[j]  <= CTR_WEAK_LOW;
    end else if (r_valid) begin
      ctr_tbl[r_hist]  <= ctr_step(ctr_tbl[r_hist], r_taken);
      hist_tbl[r_idx]  <= {r_hist[HIST_W-2:0], r_taken};
    end
  end

  // R6: outcome lands in bit 0 of the addressed history register
  a_r6_local_shift: assert property (@(posedge clk) disable iff (rst)
    r_valid |=> hist_tbl[$past(r_idx)][0] == $past(r_taken));

  // R7: a taken outcome below saturation raises the counter by one
  a_r7_local_up: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_taken && ctr_tbl[r_hist] != 2'd3)
      |=> ctr_tbl[$past(r_hist)] == $past(ctr_tbl[r_hist]) + 2'd1);
endmodule

// File: rtl/tourn_global.sv
module tourn_global
  import tourn_pkg::*;
#(
  parameter int HIST_W = 12
) (
  input  logic clk,
  input  logic rst,
  output logic f_dir,
  input  logic r_valid,
  input  logic r_taken
);
  localparam int CTR_N = 1 << HIST_W;

  logic [HIST_W-1:0] ghist;
  ctr2_t             ctr_tbl [CTR_N];

  assign f_dir = ctr_tbl[ghist][1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ghist <= '0;
      for (int j = 0; j < CTR_N; j++) ctr_tbl[j] <= CTR_WEAK_LOW;
    end else if (r_valid) begin
      ctr_tbl[ghist] <= ctr_step(ctr_tbl[ghist], r_taken);
      ghist          <= {ghist[HIST_W-2:0], r_taken};
    end
  end

  // R6: global history shifts left with the new outcome in bit 0
  a_r6_ghist_shift: assert property (@(posedge clk) disable iff (rst)
    r_valid |=> (ghist[0] == $past(r_taken)) &&
                (ghist[HIST_W-1:1] == $past(ghist[HIST_W-2:0])));

  // R7: a not-taken outcome above zero lowers the counter by one
  a_r7_global_down: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_taken && ctr_tbl[ghist] != 2'd0)
      |=> ctr_tbl[$past(ghist)] == $past(ctr_tbl[ghist]) - 2'd1);
endmodule

// File: rtl/tourn_chooser.sv
module tourn_chooser
  import tourn_pkg::*;
#(
  parameter int ENTRIES = 1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(ENTRIES)-1:0] f_idx,
  output logic                       f_use_global,
  input  logic                       r_valid,
  input  logic [$clog2(ENTRIES)-1:0] r_idx,
  input  logic                       r_taken,
  input  logic                       r_local,
  input  logic                       r_global
);
  ctr2_t sel_tbl [ENTRIES];
  logic  disagree;

  assign f_use_global = sel_tbl[f_idx][1];
  assign disagree     = r_local ^ r_global;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) sel_tbl[i] <= CTR_WEAK_LOW;
    end else if (r_valid && disagree) begin
      sel_tbl[r_idx] <= ctr_step(sel_tbl[r_idx], r_global == r_taken);
    end
  end

  // R8: agreeing saved predictions leave the selector untouched
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (r_valid && (r_local == r_global))
      |=> sel_tbl[$past(r_idx)] == $past(sel_tbl[r_idx]));
endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor
  import tourn_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int L_ENTRIES = 1024,
  parameter int L_HIST_W  = 10,
  parameter int G_HIST_W  = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic            res_local,
  input  logic            res_global
);
  localparam int IDX_W = $clog2(L_ENTRIES);
  localparam int IDX_LO = 2;

  logic [IDX_W-1:0] f_idx, r_idx;
  logic             l_dir, g_dir, use_g;
  logic             unused_pc_bits;

  assign f_idx = fetch_pc[IDX_LO +: IDX_W];
  assign r_idx = res_pc[IDX_LO +: IDX_W];
  assign unused_pc_bits = ^{fetch_pc[PC_W-1:IDX_LO+IDX_W], fetch_pc[IDX_LO-1:0],
                            res_pc[PC_W-1:IDX_LO+IDX_W], res_pc[IDX_LO-1:0]};

  tourn_local #(.ENTRIES(L_ENTRIES), .HIST_W(L_HIST_W)) u_local (
    .clk(clk), .rst(rst), .f_idx(f_idx), .f_dir(l_dir),
    .r_valid(res_valid), .r_idx(r_idx), .r_taken(res_taken)
  );

  tourn_global #(.HIST_W(G_HIST_W)) u_global (
    .clk(clk), .rst(rst), .f_dir(g_dir),
    .r_valid(res_valid), .r_taken(res_taken)
  );

  tourn_chooser #(.ENTRIES(L_ENTRIES)) u_chooser (
    .clk(clk), .rst(rst), .f_idx(f_idx), .f_use_global(use_g),
    .r_valid(res_valid), .r_idx(r_idx), .r_taken(res_taken),
    .r_local(res_local), .r_global(res_global)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_taken  <= 1'b0;
      pred_local  <= 1'b0;
      pred_global <= 1'b0;
    end else begin
      pred_valid <= fetch_valid;
      if (fetch_valid) begin
        pred_local  <= l_dir;
        pred_global <= g_dir;
        pred_taken  <= use_g ? g_dir : l_dir;
      end
    end
  end

  // R2: valid strobe follows the fetch request by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid);

  // R5: when the components agree the final direction cannot differ
  a_r5_agree_pick: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && (pred_local == pred_global)) |-> pred_taken == pred_local);
endmodule

// File: tb/tourn_predictor_tb.sv
module tourn_predictor_tb;
  localparam int LN = 1024;
  localparam int LW = 10;
  localparam int GW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_valid, pred_taken, pred_local, pred_global;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0, res_local = 1'b0, res_global = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  int m_lhist [LN];
  int m_lctr  [1 << LW];
  int m_gctr  [1 << GW];
  int m_sel   [LN];
  int m_ghist;

  always #10 clk = ~clk;

  tourn_predictor u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_local(pred_local),
    .pred_global(pred_global), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_local(res_local), .res_global(res_global)
  );

  function automatic int idx_of(logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction
  function automatic bit exp_local(logic [31:0] pc);
    return m_lctr[m_lhist[idx_of(pc)]] >= 2;
  endfunction
  function automatic bit exp_global();
    return m_gctr[m_ghist] >= 2;
  endfunction
  function automatic bit exp_taken(logic [31:0] pc);
    return (m_sel[idx_of(pc)] >= 2) ? exp_global() : exp_local(pc);
  endfunction
  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < LN; i++) begin m_lhist[i] = 0; m_sel[i] = 1; end
    for (int i = 0; i < (1 << LW); i++) m_lctr[i] = 1;
    for (int i = 0; i < (1 << GW); i++) m_gctr[i] = 1;
    m_ghist = 0;
  endtask

  task automatic model_resolve(logic [31:0] pc, bit t, bit sl, bit sg);
    int ix = idx_of(pc);
    int h  = m_lhist[ix];
    m_lctr[h]       = sat(m_lctr[h], t);
    m_lhist[ix]     = ((h << 1) | int'(t)) & ((1 << LW) - 1);
    m_gctr[m_ghist] = sat(m_gctr[m_ghist], t);
    m_ghist         = ((m_ghist << 1) | int'(t)) & ((1 << GW) - 1);
    if (sl != sg) m_sel[ix] = sat(m_sel[ix], sg == t);
  endtask

  task automatic chk(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // fetch, optionally with a resolve in the same cycle (R9)
  task automatic step(logic [31:0] pc, bit do_res, logic [31:0] rpc,
                      bit t, bit sl, bit sg, string req);
    bit el, eg, et;
    el = exp_local(pc); eg = exp_global(); et = exp_taken(pc);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    res_valid = do_res; res_pc = rpc; res_taken = t; res_local = sl; res_global = sg;
    @(negedge clk);
    fetch_valid = 1'b0; res_valid = 1'b0;
    if (do_res) model_resolve(rpc, t, sl, sg);
    chk(pred_valid,  1'b1, {req, " R2 valid"});
    chk(pred_local,  el,   {req, " R3 local"});
    chk(pred_global, eg,   {req, " R4 global"});
    chk(pred_taken,  et,   {req, " R5 final"});
    @(negedge clk);
    chk(pred_valid, 1'b0, {req, " R2 strobe"});
  endtask

  task automatic resolve(logic [31:0] pc, bit t, bit sl, bit sg);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_taken = t; res_local = sl; res_global = sg;
    @(negedge clk);
    res_valid = 1'b0;
    model_resolve(pc, t, sl, sg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pcs [8];
    void'($urandom(32'd2024));
    model_reset();
    pcs[0] = 32'h0000_0100; pcs[1] = 32'h0000_0104; pcs[2] = 32'h0000_0240;
    pcs[3] = 32'h0000_1100; pcs[4] = 32'h0000_0ffc; pcs[5] = 32'h8000_0104;
    pcs[6] = 32'h0000_0800; pcs[7] = 32'h0000_0103;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pred_valid, 1'b0, "R1 valid low in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(pred_valid, 1'b0, "R1 valid low after reset");
    // R1: reset state gives not-taken everywhere, local selected
    step(32'h0, 0, 0, 0, 0, 0, "R1 reset");

    // R7 + R8 directed: saturate global-favouring selector, then watch it pick global
    for (int k = 0; k < 4; k++) resolve(32'h0000_0200, 1'b1, 1'b0, 1'b1);
    step(32'h0000_0200, 0, 0, 0, 0, 0, "R8 sel high");
    // R8: agreement leaves selector alone
    for (int k = 0; k < 3; k++) resolve(32'h0000_0200, 1'b0, 1'b1, 1'b1);
    step(32'h0000_0200, 0, 0, 0, 0, 0, "R8 hold");
    // R8: local-only correct pulls it back
    for (int k = 0; k < 4; k++) resolve(32'h0000_0200, 1'b0, 1'b0, 1'b1);
    step(32'h0000_0200, 0, 0, 0, 0, 0, "R8 sel low");
    // R10: aliased PC sees the same per-branch state
    step(32'h0001_0201, 0, 0, 0, 0, 0, "R10 alias");
    // R7: long taken run saturates counters
    for (int k = 0; k < 14; k++) resolve(32'h0000_0300, 1'b1, 1'b1, 1'b1);
    step(32'h0000_0300, 0, 0, 0, 0, 0, "R7 saturate");
    // R9: resolve in the same cycle flips nothing in this fetch
    step(32'h0000_0300, 1, 32'h0000_0300, 1'b0, 1'b0, 1'b1, "R9 same cycle");

    // random mix
    for (int it = 0; it < 800; it++) begin
      int s = int'($urandom % 8);
      bit t, sl, sg;
      t = (s < 4) ? (($urandom % 10) < 8) : (($urandom % 10) < 3);
      if ($urandom % 2) begin sl = exp_local(pcs[s]); sg = exp_global(); end
      else begin sl = $urandom % 2; sg = $urandom % 2; end
      if (it % 40 == 0)
        step(pcs[s], 1, pcs[s], t, sl, sg, "R9 random same cycle");
      else begin
        step(pcs[s], 0, 0, 0, 0, 0, "R6 R7 R8 random");
        resolve(pcs[s], t, sl, sg);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule